// File: doc/BRIEF.md
# Multichannel Audio Slot Remapper

This block sits between a sample FIFO and an audio packet builder and changes the channel order of interleaved PCM audio. Each input word is 32 bits wide, and the audio sample sits in its low 24 bits. Words arrive one frame at a time, with every channel of one sampling instant in sequence, for example L, R, C, LFE, then the next instant. The block collects one whole frame into a small buffer. It then sends the frame out in output slot order. For every slot, a per-slot 3-bit offset chooses which buffered channel fills it.

The source channel for slot `s` is `(s + offset[s]) mod N`. `N` is the active channel count, so the wrap happens at 2, 4, 6 or 8 and not at 8 in general. The stereo layout always carries two channels. The multichannel layout carries 2, 4, 6 or 8 channels, chosen by a 2-bit code. The configuration is captured once per frame, so each frame uses one consistent setting. Any odd-count padding and any sample format conversion are done upstream of this block.

Top module: `channel_remapper`

## Requirements
- R1: While reset is held and in the first cycle after it, `outValid` is 0 and `inReady` is 1.
- R2: The frame size N comes from the configuration. When `cfgLayout`=0 (stereo), N is 2 whatever `cfgChanCode` holds. When `cfgLayout`=1 (multichannel), codes 0, 1, 2 and 3 give N of 2, 4, 6 and 8. Each frame accepts exactly N words and emits exactly N samples.
- R3: No sample is emitted until all N words of a frame have been accepted. `inReady` is 0 for as long as `outValid` is 1.
- R4: The samples of a frame are emitted with `outChan` counting 0, 1, …, N-1. The first sample of each frame carries slot 0.
- R5: The offset for slot s is `cfgSwap[3s+2:3s]`. The sample emitted for slot s is input channel `(s + offset) mod N` of the same frame.
- R6: With every offset at zero, the output sequence equals the input sequence.
- R7: The modulo wraps at N and not at 8. For example, with N=4 an offset of 3 on slot 2 selects channel 1.
- R8: `outData` is bits 23:0 of the selected input word. Bits 31:24 of the input have no effect on the output.
- R9: The configuration is captured in the cycle the first word of a frame is accepted. Changes made later in that frame do not affect it and apply from the next frame.
- R10: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData` and `outChan` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLayout | input | 1 | 0 = stereo, 1 = multichannel |
| cfgChanCode | input | 2 | Multichannel count code: N = 2*(code+1) |
| cfgSwap | input | 24 | Eight 3-bit per-slot offsets, slot s at bits 3s+2:3s |
| inValid | input | 1 | Input word available |
| inData | input | 32 | Input word, audio in bits 23:0 |
| inReady | output | 1 | Block accepts an input word |
| outValid | output | 1 | Remapped sample available |
| outReady | input | 1 | Downstream accepts the sample |
| outData | output | 24 | Remapped audio sample |
| outChan | output | 3 | Output slot index of the sample |

## Verification
The assertions assume the sink follows the valid/ready rules at the output and that the source does not count on words being taken during emission. The stall property depends on the frame buffer staying unchanged while a frame drains. The bench changes the configuration only at a falling edge and only between whole frames, with one exception: the test that deliberately changes it after the first word to show it has no effect. It also stalls the output only while `outValid` is high, so these assumptions are never broken.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int MAX_CH = 8;
  localparam int CH_W   = $clog2(MAX_CH);
  localparam int OFS_W  = CH_W;
  localparam int CNT_W  = CH_W + 1;
  localparam int CODE_W = 2;

  typedef struct packed {
    logic            wrEn;
    logic [CH_W-1:0] wrIdx;
    logic            cfgLoad;
    logic [CH_W-1:0] rdSlot;
  } ctrlStrobes_t;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             outReady,
  input  logic [CNT_W-1:0] chanCount,
  output logic             inReady,
  output logic             outValid,
  output logic [CH_W-1:0]  outChan,
  output ctrlStrobes_t     strobes
);
  typedef enum logic {ST_FILL, ST_SEND} state_t;

  state_t          state;
  logic [CH_W-1:0] idx;
  logic            atLast;

  assign inReady  = (state == ST_FILL);
  assign outValid = (state == ST_SEND);
  assign outChan  = idx;
  assign atLast   = ({1'b0, idx} == (chanCount - CNT_W'(1)));

  always_comb begin
    strobes.wrEn    = inValid && inReady;
    strobes.wrIdx   = idx;
    strobes.cfgLoad = (state == ST_FILL) && (idx == '0);
    strobes.rdSlot  = idx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_FILL;
      idx   <= '0;
    end else begin
      case (state)
        ST_FILL: if (inValid) begin
          if (atLast) begin
            state <= ST_SEND;
            idx   <= '0;
          end else begin
            idx <= idx + CH_W'(1);
          end
        end
        ST_SEND: if (outReady) begin
          if (atLast) begin
            state <= ST_FILL;
            idx   <= '0;
          end else begin
            idx <= idx + CH_W'(1);
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end
endmodule

// File: rtl/remap_datapath.sv
module remap_datapath
  import remap_pkg::*;
#(
  parameter int AUD_W = 24
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [AUD_W-1:0]       inSample,
  input  logic                   cfgLayout,
  input  logic [CODE_W-1:0]      cfgChanCode,
  input  logic [MAX_CH*OFS_W-1:0] cfgSwap,
  output logic [CNT_W-1:0]       chanCount,
  output logic [AUD_W-1:0]       outSample
);
  localparam int SUM_W = CNT_W;

  logic [AUD_W-1:0]        frameBuf [MAX_CH];
  logic                    heldLayout;
  logic [CODE_W-1:0]       heldCode;
  logic [MAX_CH*OFS_W-1:0] heldSwap;
  logic [OFS_W-1:0]        slotOfs [MAX_CH];
  logic [SUM_W-1:0]        rawSum;
  logic [SUM_W-1:0]        srcIdx;

  function automatic logic [SUM_W-1:0] wrapAt(input logic [SUM_W-1:0] v,
                                                input logic [SUM_W-1:0] n);
    logic [SUM_W-1:0] r;
    r = v;
    for (int i = 0; i < MAX_CH - 1; i++) begin
      if (r >= n) r = r - n;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldLayout <= 1'b0;
      heldCode   <= '0;
      heldSwap   <= '0;
    end else if (strobes.cfgLoad) begin
      heldLayout <= cfgLayout;
      heldCode   <= cfgChanCode;
      heldSwap   <= cfgSwap;
    end
  end

  for (genvar g = 0; g < MAX_CH; g++) begin : g_slot
    assign slotOfs[g] = heldSwap[g*OFS_W +: OFS_W];
    always_ff @(posedge clk) begin
      if (strobes.wrEn && (strobes.wrIdx == CH_W'(g))) frameBuf[g] <= inSample;
    end
  end

  assign chanCount = heldLayout ? ((CNT_W'(heldCode) + CNT_W'(1)) << 1) : CNT_W'(2);
  assign rawSum    = SUM_W'(strobes.rdSlot) + SUM_W'(slotOfs[strobes.rdSlot]);
  assign srcIdx    = wrapAt(rawSum, chanCount);
  assign outSample = frameBuf[srcIdx[CH_W-1:0]];
endmodule

// File: rtl/channel_remapper.sv
module channel_remapper
  import remap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int AUD_W  = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgLayout,
  input  logic [CODE_W-1:0]       cfgChanCode,
  input  logic [MAX_CH*OFS_W-1:0] cfgSwap,
  input  logic                    inValid,
  input  logic [WORD_W-1:0]       inData,
  output logic                    inReady,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [AUD_W-1:0]        outData,
  output logic [CH_W-1:0]         outChan
);
  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] chanCount;
  logic             unusedUpper;

  assign unusedUpper = ^inData[WORD_W-1:AUD_W];

  remap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .chanCount(chanCount), .inReady(inReady), .outValid(outValid),
    .outChan(outChan), .strobes(strobes)
  );

  remap_datapath #(.AUD_W(AUD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inSample(inData[AUD_W-1:0]),
    .cfgLayout(cfgLayout), .cfgChanCode(cfgChanCode), .cfgSwap(cfgSwap),
    .chanCount(chanCount), .outSample(outData)
  );
endmodule

// File: rtl/remap_checker.sv
module remap_checker #(
  parameter int AUD_W = 24,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [AUD_W-1:0] outData,
  input logic [CH_W-1:0]  outChan
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outChan)); // R10
  AST_NO_ACCEPT_WHILE_SEND: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady); // R3
  AST_FRAME_STARTS_SLOT0: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outChan == '0); // R4
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady |=> !outValid || outChan == $past(outChan) + CH_W'(1)); // R4
endmodule

bind channel_remapper remap_checker #(.AUD_W(AUD_W), .CH_W(remap_pkg::CH_W)) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .outData(outData), .outChan(outChan)
);

// File: tb/tb_channel_remapper.sv
`timescale 1ns/100ps
module tb_channel_remapper;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgLayout;
  logic [1:0]  cfgChanCode;
  logic [23:0] cfgSwap;
  logic        inValid;
  logic [31:0] inData;
  logic        inReady;
  logic        outValid;
  logic        outReady;
  logic [23:0] outData;
  logic [2:0]  outChan;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  channel_remapper dut (
    .clk(clk), .rstN(rstN), .cfgLayout(cfgLayout), .cfgChanCode(cfgChanCode),
    .cfgSwap(cfgSwap), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outChan(outChan)
  );

  // {layout, code, swap[23:0], seed[7:0]}
  localparam logic [34:0] VEC [8] = '{
    {1'b1, 2'd3, 24'o00000000, 8'h11},  // R6 identity, 8 channels
    {1'b0, 2'd3, 24'o00000000, 8'h22},  // R2 stereo ignores code
    {1'b0, 2'd0, 24'o00000011, 8'h33},  // R5 stereo swap L/R
    {1'b1, 2'd1, 24'o00000300, 8'h44},  // R7 4ch, slot2 offset 3 -> ch1
    {1'b1, 2'd2, 24'o77777777, 8'h55},  // R7 6ch, offset 7 wraps
    {1'b1, 2'd3, 24'o76543210, 8'h66},  // R5 8ch, offset s
    {1'b1, 2'd0, 24'o00000003, 8'h77},  // R2 2ch multichannel
    {1'b1, 2'd1, 24'o77770000, 8'h88}   // R6 unused slot offsets ignored
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input logic [7:0] seed, input int ch);
    return {~seed, seed, 8'(ch), 8'(ch * 17)};
  endfunction

  task automatic sendWord(input logic [31:0] w);
    inData  = w;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic recvWord(output logic [23:0] d, output logic [2:0] c);
    outReady = 1'b1;
    while (!outValid) @(negedge clk);
    check(inReady == 1'b0, "R3 inReady during send", int'(inReady), 0);
    d = outData;
    c = outChan;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] seed, input int n);
    for (int ch = 0; ch < n; ch++) begin
      sendWord(mkWord(seed, ch));
      if (ch < n - 1) check(outValid == 1'b0, "R3 early output", int'(outValid), 0);
    end
  endtask

  task automatic recvFrame(input logic [7:0] seed, input int n, input logic [23:0] swap,
                           input string tag);
    logic [23:0] d;
    logic [2:0]  c;
    for (int s = 0; s < n; s++) begin
      int src;
      logic [31:0] w;
      src = (s + int'(swap[3*s +: 3])) % n;
      w   = mkWord(seed, src);
      recvWord(d, c);
      check(c == 3'(s), "R4 slot order", int'(c), s);
      check(d == w[23:0], tag, int'(d), int'(w[23:0]));
    end
    check(outValid == 1'b0 && inReady == 1'b1, "R2 frame length", int'(outValid), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [23:0] d;
    logic [2:0]  c;
    rstN = 1'b0; inValid = 1'b0; inData = '0; outReady = 1'b0;
    cfgLayout = 1'b0; cfgChanCode = '0; cfgSwap = '0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && inReady == 1'b1, "R1 in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && inReady == 1'b1, "R1 after reset", int'(outValid), 0);

    // Table-driven frames
    for (int v = 0; v < 8; v++) begin
      int n;
      cfgLayout   = VEC[v][34];
      cfgChanCode = VEC[v][33:32];
      cfgSwap     = VEC[v][31:8];
      n = cfgLayout ? 2 * (int'(cfgChanCode) + 1) : 2;
      sendFrame(VEC[v][7:0], n);
      recvFrame(VEC[v][7:0], n, VEC[v][31:8], "R5/R6/R7/R8 data");
    end

    // R10: stall the output and watch it hold
    cfgLayout = 1'b1; cfgChanCode = 2'd1; cfgSwap = 24'o00000012;
    sendFrame(8'h9A, 4);
    check(outValid == 1'b1, "R10 frame ready", int'(outValid), 1);
    for (int k = 0; k < 3; k++) begin
      logic [23:0] dPrev;
      logic [2:0]  cPrev;
      dPrev = outData; cPrev = outChan;
      @(negedge clk);
      check(outValid && outData == dPrev && outChan == cPrev, "R10 hold under stall",
            int'(outData), int'(dPrev));
    end
    recvFrame(8'h9A, 4, 24'o00000012, "R10 data after stall");

    // R9: config change after the first word does not affect the frame
    cfgLayout = 1'b1; cfgChanCode = 2'd1; cfgSwap = 24'o00003210;
    sendWord(mkWord(8'hB1, 0));
    cfgChanCode = 2'd3; cfgSwap = 24'o11111111;
    for (int ch = 1; ch < 4; ch++) sendWord(mkWord(8'hB1, ch));
    recvFrame(8'hB1, 4, 24'o00003210, "R9 old config held");
    sendFrame(8'hB2, 8);
    recvFrame(8'hB2, 8, 24'o11111111, "R9 new config applied");

    // R8: upper byte differs, output unaffected
    cfgLayout = 1'b0; cfgSwap = '0;
    sendWord(32'hFF123456);
    sendWord(32'h00ABCDEF);
    recvWord(d, c);
    check(d == 24'h123456, "R8 upper bits ignored", int'(d), 'h123456);
    recvWord(d, c);
    check(d == 24'hABCDEF, "R8 upper bits ignored", int'(d), 'hABCDEF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule